// File: doc/BRIEF.md
# Five-Counter Performance Monitor

This block gives software a view of how often hardware events happen. It holds one cycle counter and four programmable 32-bit event counters. Each event counter watches one line of a 32-bit event-strobe bus, and an 8-bit code picks the line. Software reaches the block through a small register port (address, write enable, write data, read enable, read data). Through that port it starts and stops counting, zeroes the counters, picks the events, and loads a counter with any value.

To sample every N events, software loads a counter with the two's complement of N. When the counter wraps from all ones to zero, it sets a sticky overflow flag. One interrupt line stays high while any flag is set whose enable bit is also set. Software clears a flag by writing a one to its bit.

Register map (4-bit address): 0 control, 1 interrupt enable, 2 overflow flags, 3 event select, 4 cycle counter, 5 to 8 event counters 0 to 3. All other addresses read as zero.

Top module: `perf_mon_unit`

## Requirements
- R1: Control bit 0 (run) gates every counter. While it is 0, no counter changes except by a register write or a zeroing strobe.
- R2: A control write with bit 1 set zeroes all four event counters. A control write with bit 2 set zeroes the cycle counter and its prescaler. Bits 1 and 2 are not stored. A control read returns run in bit 0, divide in bit 3, and zero in every other bit.
- R3: While run is set, the cycle counter advances on every clock. When control bit 3 (divide) is also set, it advances once every 64 enabled clocks instead.
- R4: The event select register holds one 8-bit code per counter: counter 0 in bits 7:0, counter 1 in 15:8, counter 2 in 23:16 and counter 3 in 31:24. While run is set, event counter k adds one on each clock in which strobe bit [code k] is high.
- R5: A code of 32 or more, including the unused marker 0xFF, never makes its counter advance.
- R6: A counter that advances from 0xFFFFFFFF to 0 sets its overflow flag. Flag bit 0 belongs to the cycle counter and bits 1 to 4 belong to event counters 0 to 3. Flags read back at address 2.
- R7: Flags are sticky. Writing a 1 to a flag bit clears it, and writing a 0 leaves it alone. A new overflow in the same cycle as a clearing write leaves the flag set.
- R8: The interrupt enable register (address 1) uses the flag bit positions. The irq output is high exactly when some flag bit and its enable bit are both set.
- R9: Every counter can be written at any time. A write in the same cycle as an increment stores the written value.
- R10: Read data for the addressed register appears on reg_rdata one clock after reg_rd is sampled high, and it holds the value from before that edge's update.
- R11: After reset, every register and counter is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read enable |
| reg_rdata | output | 32 | Registered read data |
| evt_strobe | input | 32 | Event pulse lines, indexed by event code |
| irq | output | 1 | Overflow interrupt |

## Verification
- **Register writes:** a write takes effect at the clock edge that samples it.
- **Reads:** read data is valid one edge later and shows the state from before that edge.
- **Flags and irq:** a wrap sets its flag at the same edge as the counter update, and irq follows combinationally from the registered flags and enables.
- **Edge counting:** the bench keeps its own count of clock edges and records the edge of each enabling write and each read capture. It computes the expected cycle count, including the divide-by-64 case, from the number of edges in between.
- **Event stimulus:** strobes are driven at falling edges and tallied into the expected counts only for edges where counting is enabled. Every result is sampled at the falling edge after it is due.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 4;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL = 4'd0;
  localparam addr_t A_IEN  = 4'd1;
  localparam addr_t A_FLAG = 4'd2;
  localparam addr_t A_ESEL = 4'd3;
  localparam addr_t A_CYC  = 4'd4;
  localparam addr_t A_EV0  = 4'd5;

  localparam int CTL_RUN  = 0;
  localparam int CTL_ZEV  = 1;
  localparam int CTL_ZCYC = 2;
  localparam int CTL_DIV  = 3;
endpackage

// File: rtl/pmu_rst_sync.sv
module pmu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_en,
  input  logic             zero_req,
  input  logic             wr_req,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic               tick, step;

  always_comb begin
    tick    = div_en ? (presc_q == {PRESC_W{1'b1}}) : 1'b1;
    step    = run && tick;
    presc_d = presc_q;
    if (zero_req)          presc_d = '0;
    else if (!div_en)      presc_d = '0;
    else if (run)          presc_d = presc_q + 1'b1;

    cnt_d = cnt_q;
    ovf_o = 1'b0;
    if (wr_req)        cnt_d = wr_data;
    else if (zero_req) cnt_d = '0;
    else if (step) begin
      cnt_d = cnt_q + 1'b1;
      ovf_o = (cnt_q == {CNT_W{1'b1}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      presc_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      presc_q <= presc_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
  parameter int CNT_W    = 32,
  parameter int CODE_W   = 8,
  parameter int STROBE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                zero_req,
  input  logic                wr_req,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [CODE_W-1:0]   code,
  input  logic [STROBE_W-1:0] strobe,
  output logic [CNT_W-1:0]    count_o,
  output logic                ovf_o
);
  localparam int IDX_W = $clog2(STROBE_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             legal, hit;

  always_comb begin
    legal = (int'(code) < STROBE_W);
    hit   = legal && strobe[code[IDX_W-1:0]];

    cnt_d = cnt_q;
    ovf_o = 1'b0;
    if (wr_req)        cnt_d = wr_data;
    else if (zero_req) cnt_d = '0;
    else if (run && hit) begin
      cnt_d = cnt_q + 1'b1;
      ovf_o = (cnt_q == {CNT_W{1'b1}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 32,
  parameter int CODE_W   = 8,
  parameter int STROBE_W = 32,
  parameter int PRESC_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [CNT_W-1:0]    reg_wdata,
  input  logic                reg_rd,
  output logic [CNT_W-1:0]    reg_rdata,
  input  logic [STROBE_W-1:0] evt_strobe,
  output logic                irq
);
  localparam int NFLAG  = NUM_EVT + 1;
  localparam int SEL_W  = NUM_EVT * CODE_W;

  logic rst_i_n;
  pmu_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // register state
  logic                             run_q, run_d, div_q, div_d;
  logic [NFLAG-1:0]                 ien_q, ien_d, flag_q, flag_d;
  logic [NUM_EVT-1:0][CODE_W-1:0]   esel_q, esel_d;
  logic [CNT_W-1:0]                 rdata_q, rdata_d, rd_mux;

  // write decode
  logic wr_ctrl, wr_ien, wr_flag, wr_esel, wr_cyc;
  logic zero_ev, zero_cyc;
  logic [NFLAG-1:0] clr_mask, ovf_vec;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    wr_ien   = reg_wr && (reg_addr == A_IEN);
    wr_flag  = reg_wr && (reg_addr == A_FLAG);
    wr_esel  = reg_wr && (reg_addr == A_ESEL);
    wr_cyc   = reg_wr && (reg_addr == A_CYC);
    zero_ev  = wr_ctrl && reg_wdata[CTL_ZEV];
    zero_cyc = wr_ctrl && reg_wdata[CTL_ZCYC];
    clr_mask = wr_flag ? reg_wdata[NFLAG-1:0] : '0;
  end

  // counters
  logic [CNT_W-1:0]                cyc_cnt;
  logic [NUM_EVT-1:0][CNT_W-1:0]   ev_cnt;
  logic [NUM_EVT-1:0]              ev_ovf;
  logic                            cyc_ovf;

  pmu_cycle_counter #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_cyc (
    .clk(clk), .rst_n(rst_i_n), .run(run_q), .div_en(div_q),
    .zero_req(zero_cyc), .wr_req(wr_cyc), .wr_data(reg_wdata),
    .count_o(cyc_cnt), .ovf_o(cyc_ovf)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    localparam addr_t MY_ADDR = addr_t'(int'(A_EV0) + i);
    logic wr_me;
    assign wr_me = reg_wr && (reg_addr == MY_ADDR);
    pmu_event_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .STROBE_W(STROBE_W)) u_ctr (
      .clk(clk), .rst_n(rst_i_n), .run(run_q), .zero_req(zero_ev),
      .wr_req(wr_me), .wr_data(reg_wdata), .code(esel_q[i]),
      .strobe(evt_strobe), .count_o(ev_cnt[i]), .ovf_o(ev_ovf[i])
    );
  end

  assign ovf_vec = {ev_ovf, cyc_ovf};

  // next-state of the register file
  always_comb begin
    run_d  = wr_ctrl ? reg_wdata[CTL_RUN] : run_q;
    div_d  = wr_ctrl ? reg_wdata[CTL_DIV] : div_q;
    ien_d  = wr_ien  ? reg_wdata[NFLAG-1:0] : ien_q;
    esel_d = wr_esel ? reg_wdata[SEL_W-1:0] : esel_q;
    flag_d = (flag_q & ~clr_mask) | ovf_vec;
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[CTL_RUN] = run_q;
        rd_mux[CTL_DIV] = div_q;
      end
      A_IEN:  rd_mux[NFLAG-1:0] = ien_q;
      A_FLAG: rd_mux[NFLAG-1:0] = flag_q;
      A_ESEL: rd_mux[SEL_W-1:0] = esel_q;
      A_CYC:  rd_mux = cyc_cnt;
      default: begin
        for (int k = 0; k < NUM_EVT; k++) begin
          if (reg_addr == addr_t'(int'(A_EV0) + k)) rd_mux = ev_cnt[k];
        end
      end
    endcase
    rdata_d = reg_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      run_q   <= 1'b0;
      div_q   <= 1'b0;
      ien_q   <= '0;
      flag_q  <= '0;
      esel_q  <= '0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      div_q   <= div_d;
      ien_q   <= ien_d;
      flag_q  <= flag_d;
      esel_q  <= esel_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = |(flag_q & ien_q);
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int CNT_W    = 32,
  parameter int CODE_W   = 8,
  parameter int STROBE_W = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             reg_wr,
  input logic [ADDR_W-1:0]                reg_addr,
  input logic [CNT_W-1:0]                 reg_wdata,
  input logic                             irq,
  input logic                             ctrl_en,
  input logic [NUM_EVT:0]                 ien,
  input logic [NUM_EVT:0]                 flags,
  input logic [CNT_W-1:0]                 cyc_cnt,
  input logic [NUM_EVT-1:0][CNT_W-1:0]    ev_cnt,
  input logic [NUM_EVT-1:0][CODE_W-1:0]   ev_sel
);
  assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !reg_wr) |=> $stable(cyc_cnt));

  assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((cyc_cnt == $past(cyc_cnt)) || (cyc_cnt == $past(cyc_cnt) + 1'b1)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(reg_wr && (reg_addr == A_FLAG)));

  assert_irq_off_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  assert_irq_off_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    localparam addr_t MY_ADDR = addr_t'(int'(A_EV0) + i);

    assert_bad_code_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(ev_sel[i]) >= STROBE_W) && !reg_wr) |=> $stable(ev_cnt[i]));

    assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_wr) && ($past(ev_cnt[i]) == {CNT_W{1'b1}}) && (ev_cnt[i] == '0))
        |-> flags[i+1]);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == MY_ADDR)) |=> (ev_cnt[i] == $past(reg_wdata)));
  end
endmodule

bind perf_mon_unit pmu_checker #(
  .NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .CODE_W(CODE_W), .STROBE_W(STROBE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .ctrl_en(run_q), .ien(ien_q),
  .flags(flag_q), .cyc_cnt(cyc_cnt), .ev_cnt(ev_cnt), .ev_sel(esel_q)
);

// File: tb/sim_perf_mon_unit.sv
module sim_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_strobe = '0;
  logic        irq;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  perf_mon_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_strobe(evt_strobe), .irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output int cap);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; cap = cyc;
  endtask

  function automatic int exp_cycles(input int m, input bit div);
    return div ? (m / 64) : m;
  endfunction

  initial begin
    logic [31:0] v;
    int w, cap;
    logic [7:0] code [4];
    int unsigned exp_ev [4];
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    chk("R11 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd0, v, cap); chk("R11 ctrl after reset", v, 32'h0);
    rd(4'd4, v, cap); chk("R11 cycle count after reset", v, 32'h0);
    rd(4'd2, v, cap); chk("R11 flags after reset", v, 32'h0);
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);

    // R2: only run and divide are stored
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v, cap); chk("R2 R10 ctrl readback", v, 32'h9);
    wr(4'd0, 32'h0);

    // R3: every cycle
    wr(4'd0, 32'h5); w = cyc;
    repeat (20) @(negedge clk);
    rd(4'd4, v, cap); chk("R3 cycle count", v, exp_cycles(cap - w - 1, 1'b0));

    // R3: divide by 64
    wr(4'd0, 32'hD); w = cyc;
    repeat (200) @(negedge clk);
    rd(4'd4, v, cap); chk("R3 divided cycle count", v, exp_cycles(cap - w - 1, 1'b1));

    // R1: stopped counters hold
    wr(4'd0, 32'h0);
    rd(4'd4, v, cap);
    begin
      logic [31:0] v2;
      repeat (30) @(negedge clk);
      rd(4'd4, v2, cap); chk("R1 cycle count holds while stopped", v2, v);
    end

    // R4: random codes and strobes, two rounds
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 4; k++) begin code[k] = 8'($urandom_range(0, 31)); exp_ev[k] = 0; end
      wr(4'd3, {code[3], code[2], code[1], code[0]});
      wr(4'd0, 32'h3);
      for (int c = 0; c < 300; c++) begin
        evt_strobe = $urandom();
        for (int k = 0; k < 4; k++) exp_ev[k] += evt_strobe[code[k][4:0]];
        @(posedge clk); @(negedge clk);
      end
      evt_strobe = '0;
      wr(4'd0, 32'h0);
      for (int k = 0; k < 4; k++) begin
        rd(4'(5 + k), v, cap);
        chk($sformatf("R4 event counter %0d round %0d", k, r), v, exp_ev[k]);
      end
    end

    // R2: event zeroing strobe
    wr(4'd0, 32'h2);
    rd(4'd5, v, cap); chk("R2 event counters zeroed", v, 32'h0);

    // R5: out-of-range and unused codes
    wr(4'd3, 32'hFF20_7FFF);
    wr(4'd0, 32'h3);
    evt_strobe = '1;
    repeat (50) @(negedge clk);
    evt_strobe = '0;
    wr(4'd0, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(4'(5 + k), v, cap); chk($sformatf("R5 counter %0d idle on bad code", k), v, 32'h0);
    end

    // R6/R8: wrap of event counter 0 on code 5
    wr(4'd3, 32'hFFFF_FF05);
    wr(4'd1, 32'h0);
    wr(4'd5, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    evt_strobe = 32'h20; @(posedge clk); @(negedge clk); evt_strobe = '0;
    rd(4'd2, v, cap); chk("R6 no flag before wrap", v, 32'h0);
    evt_strobe = 32'h20; @(posedge clk); @(negedge clk); evt_strobe = '0;
    rd(4'd2, v, cap); chk("R6 flag after wrap", v, 32'h2);
    rd(4'd5, v, cap); chk("R6 counter wrapped to zero", v, 32'h0);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(4'd1, 32'h2);
    chk("R8 irq enabled", {31'b0, irq}, 32'h1);
    wr(4'd1, 32'h1);
    chk("R8 irq other enable", {31'b0, irq}, 32'h0);

    // R7: write-one-to-clear
    wr(4'd2, 32'h1D);
    rd(4'd2, v, cap); chk("R7 zero bits leave flag", v, 32'h2);
    wr(4'd2, 32'h2);
    rd(4'd2, v, cap); chk("R7 one clears flag", v, 32'h0);

    // R7: overflow in same cycle as clear
    wr(4'd5, 32'hFFFF_FFFF);
    evt_strobe = 32'h20;
    wr(4'd2, 32'h2);
    evt_strobe = '0;
    rd(4'd2, v, cap); chk("R7 new overflow beats clear", v, 32'h2);
    wr(4'd2, 32'h1F);

    // R9: write beats increment
    evt_strobe = 32'h20;
    wr(4'd5, 32'h0000_1234);
    evt_strobe = '0;
    wr(4'd0, 32'h0);
    rd(4'd5, v, cap); chk("R9 write priority", v, 32'h0000_1234);

    // R6/R8: cycle counter wrap
    wr(4'd4, 32'hFFFF_FFFE);
    rd(4'd4, v, cap); chk("R9 cycle counter write", v, 32'hFFFF_FFFE);
    wr(4'd0, 32'h1);
    repeat (3) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd2, v, cap); chk("R6 cycle flag", v, 32'h1);
    chk("R8 irq on cycle flag", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule